// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block holds a bank of 256 byte-wide configuration registers that a host reaches through two adjacent byte addresses on a simple synchronous I/O port. The host first writes a register number to the lower address, the selector port. It then reads or writes the chosen register through the upper address, the value port. Each value write passes a per-register filter. Whole ranges of registers are read-only. Two base-address registers each accept exactly one value and drop every other.

An external enable, taken from one bit of a host configuration byte, decides whether the pair of addresses is decoded at all. While the enable is low, the block ignores every access and returns an all-ones byte. Reset loads fixed values into six registers and clears the selector and every other register. Read data appears one clock after the read strobe and holds until the next read.

Top module: `cfg_window_port`

## Requirements
- R1: A write to address 0x3F0 while the window is enabled loads the 8-bit selector with the write data.
- R2: A read strobe at 0x3F1 while the window is enabled places the selected register's value on the read data one cycle later.
- R3: A value write is dropped, leaving the selected register unchanged, when the selector is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: Register 0xE7 takes a value write only when the data is 0xFE, and register 0xE8 only when it is 0xBE; any other data leaves them unchanged.
- R5: Registers 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any value written through the value port.
- R6: After reset the selector is 0x00; registers 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE; every other register is 0x00.
- R7: While the window enable is low, writes change neither the selector nor any register, and a read returns 0xFF one cycle later.
- R8: Accesses at addresses other than 0x3F0 and 0x3F1 have no effect on the selector or registers, and reads of them return 0xFF one cycle later.
- R9: A read strobe at 0x3F0 while enabled returns the selected register, the same as the value port.
- R10: The read data is 0xFF after reset and keeps its value in every cycle that follows a cycle without a read strobe; a read in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_en | input | 1 | Window decode enable from the host configuration bit |
| bus_addr | input | 16 | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |

## Verification
The assertions take for granted that every access is a single-cycle strobe on one address, so the selector cannot change in the same cycle as a value write. They also assume that the enable and address are stable in the cycle the strobe is sampled. The bench drives all inputs on the falling edge, with exactly one address per cycle. It mixes enable-low periods, out-of-window addresses and combined read and write strobes with a behavioural model that orders the read before the write.

// File: rtl/cfg_window_pkg.sv
// Package: shared constants and reset contents for the indexed
// configuration window. Assumes byte-wide registers.
package cfg_window_pkg;

    localparam int BYTE_W = 8;

    // Only values the two base-address registers will take
    localparam logic [7:0] IDX_BASE_A = 8'hE7;
    localparam logic [7:0] KEY_BASE_A = 8'hFE;
    localparam logic [7:0] IDX_BASE_B = 8'hE8;
    localparam logic [7:0] KEY_BASE_B = 8'hBE;

    // Value the read bus carries for an undecoded or idle read
    localparam logic [7:0] FLOAT_BYTE = 8'hFF;

    // Reset contents for one register, computed per index
    function automatic logic [7:0] reset_value(input int unsigned idx);
        case (idx)
            32'hE0:  return 8'h3C;
            32'hE2:  return 8'h03;
            32'hE3:  return 8'hFC;
            32'hE6:  return 8'hDE;
            32'hE7:  return KEY_BASE_A;
            32'hE8:  return KEY_BASE_B;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_window_decode.sv
// Module: address decode for the two-byte window.
// Assumes one address per cycle and single-cycle strobes. Produces
// strobes for the selector port, the value port and an in-window read.
module cfg_window_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h03F0
) (
    input  logic              win_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              sel_wr,
    output logic              val_wr,
    output logic              win_rd
);
    localparam logic [ADDR_W-1:0] VAL_ADDR = WIN_BASE + ADDR_W'(1);

    logic hit_sel;
    logic hit_val;

    // Match each port address, qualified by the window enable
    always_comb begin
        hit_sel = win_en && (bus_addr == WIN_BASE);
        hit_val = win_en && (bus_addr == VAL_ADDR);
        sel_wr  = bus_wr && hit_sel;
        val_wr  = bus_wr && hit_val;
        win_rd  = bus_rd && (hit_sel || hit_val);
    end

endmodule

// File: rtl/cfg_write_filter.sv
// Module: per-register write filter. Purely combinational.
// Assumes an 8-bit selector; decides whether a value write lands.
module cfg_write_filter
    import cfg_window_pkg::*;
(
    input  logic [7:0] sel_idx,
    input  logic [7:0] wr_byte,
    output logic       accept
);
    // Read-only ranges, keyed registers, everything else open
    always_comb begin
        case (sel_idx) inside
            [8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED],
            8'hF3, 8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]:
                accept = 1'b0;
            IDX_BASE_A: accept = (wr_byte == KEY_BASE_A);
            IDX_BASE_B: accept = (wr_byte == KEY_BASE_B);
            default:    accept = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_regfile.sv
// Module: byte register bank with per-entry reset contents.
// Assumes at most one write per cycle; provides one combinational
// read port addressed by the current selector.
module cfg_regfile
    import cfg_window_pkg::*;
#(
    parameter int NUM_REGS = 256,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        // One register: load reset contents, else take a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= reset_value(i);
            end else if (we && (widx == IDX_W'(i))) begin
                q[i] <= wdata;
            end
        end
    end

    // Read port for the selected entry
    assign rdata = q[ridx];

    if (NUM_REGS > 32'hE8) begin : g_key_chk
        // R4: the keyed base registers can only ever hold their key value
        a_r4_keys_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (q[IDX_BASE_A] == KEY_BASE_A) && (q[IDX_BASE_B] == KEY_BASE_B));
    end

endmodule

// File: rtl/cfg_window_port.sv
// Module: top of the indexed configuration window. Holds the selector
// and the registered read data, and joins decode, filter and bank.
// Assumes single-cycle strobes and one address per cycle; a read and
// a write in the same cycle see the state from before the write.
module cfg_window_port
    import cfg_window_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h03F0,
    parameter int                NUM_REGS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             sel_wr;
    logic             val_wr;
    logic             win_rd;
    logic             accept;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       sel_data;

    cfg_window_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .win_en   (win_en),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .sel_wr   (sel_wr),
        .val_wr   (val_wr),
        .win_rd   (win_rd)
    );

    cfg_write_filter u_filter (
        .sel_idx (8'(idx_q)),
        .wr_byte (bus_wdata),
        .accept  (accept)
    );

    cfg_regfile #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (val_wr && accept),
        .widx  (idx_q),
        .wdata (bus_wdata),
        .ridx  (idx_q),
        .rdata (sel_data)
    );

    // Selector register: cleared by reset, loaded by a selector write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sel_wr) begin
            idx_q <= IDX_W'(bus_wdata);
        end
    end

    // Read data register: updated on every read strobe, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= FLOAT_BYTE;
        end else if (bus_rd) begin
            bus_rdata <= win_rd ? sel_data : FLOAT_BYTE;
        end
    end

    // R1: a decoded selector write lands in the selector
    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && bus_wr && bus_addr == WIN_BASE)
        |=> (idx_q == IDX_W'($past(bus_wdata))));

    // R5 (and R4 with the key): a value write the filter passes is stored
    a_r5_accepted_store: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && accept) |=> (sel_data == $past(bus_wdata)));

    // R3 and R4: a value write the filter refuses leaves the register as it was
    a_r3_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !accept) |=> $stable(sel_data));

    // R7: with the window off, the selector cannot move
    a_r7_off_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> $stable(idx_q));

    // R7: with the window off, reads return the idle byte
    a_r7_off_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !win_en) |=> (bus_rdata == FLOAT_BYTE));

    // R10: without a read strobe the read data holds
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/cfg_window_port_tb.sv
// Bench: behavioural reference model compared with the read data on
// every falling edge; stimulus driven on the falling edge.
module cfg_window_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_en = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R6";

    int m_regs [256];
    int m_idx;
    int m_rdata;

    always #2 clk = ~clk;   // 250 MHz

    cfg_window_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_en    (win_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Reset contents written from the requirement (R6)
    function automatic int m_default(int i);
        if (i == 'hE0) return 'h3C;
        if (i == 'hE2) return 'h03;
        if (i == 'hE3) return 'hFC;
        if (i == 'hE6) return 'hDE;
        if (i == 'hE7) return 'hFE;
        if (i == 'hE8) return 'hBE;
        return 0;
    endfunction

    // Write permission from the open list (R5) and keys (R4); all else R3
    function automatic bit m_open(int i, int d);
        if (i >= 'hE0 && i <= 'hE3) return 1;
        if (i == 'hE6 || i == 'hF4 || i == 'hF6 || i == 'hF8 || i == 'hFC) return 1;
        if (i >= 'hEE && i <= 'hF2) return 1;
        if (i == 'hE7) return d == 'hFE;
        if (i == 'hE8) return d == 'hBE;
        return 0;
    endfunction

    // Reference model: read sampled before any write in the same cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_regs[i] = m_default(i);
            m_idx   = 0;
            m_rdata = 'hFF;
        end else begin
            bit in_win;
            in_win = win_en && (bus_addr == 16'h03F0 || bus_addr == 16'h03F1);
            if (bus_rd) m_rdata = in_win ? m_regs[m_idx] : 'hFF;
            if (bus_wr && win_en) begin
                if (bus_addr == 16'h03F0) m_idx = bus_wdata;
                else if (bus_addr == 16'h03F1 && m_open(m_idx, bus_wdata))
                    m_regs[m_idx] = bus_wdata;
            end
        end
    end

    // Compare at the falling edge, then drive the next cycle's inputs
    task automatic step(input bit en, input logic [15:0] a,
                        input bit wr, input bit rd, input logic [7:0] d);
        @(negedge clk);
        if (cmp_on) begin
            n_cmp++;
            if (int'(bus_rdata) != m_rdata) begin
                n_bad++;
                $display("FAIL %s: rdata actual %02h expected %02h at %0t",
                         cur_req, bus_rdata, m_rdata[7:0], $time);
            end
        end
        win_en = en; bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    endtask

    task automatic set_idx(input logic [7:0] i);
        step(1, 16'h03F0, 1, 0, i);
    endtask

    task automatic rd_val();
        step(1, 16'h03F1, 0, 1, 8'h00);
        step(1, 16'h03F1, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cur_req = "R10";                    // R10: reset value of read data
        step(0, 16'h0000, 0, 0, 8'h00);

        cur_req = "R7";                     // R7: window disabled
        step(0, 16'h03F0, 1, 0, 8'hE0);
        step(0, 16'h03F1, 1, 0, 8'h55);
        step(0, 16'h03F1, 0, 1, 8'h00);
        step(0, 16'h03F0, 0, 1, 8'h00);
        step(1, 16'h03F1, 0, 1, 8'h00);     // index still 0x00
        step(1, 16'h0000, 0, 0, 8'h00);

        cur_req = "R6";                     // R6 and R2: sweep reset contents
        for (int i = 0; i < 256; i++) begin
            set_idx(8'(i));
            rd_val();
        end

        cur_req = "R3";                     // R3, R5: write 0xA5 to each index
        for (int i = 0; i < 256; i++) begin
            set_idx(8'(i));
            step(1, 16'h03F1, 1, 0, 8'hA5);
            rd_val();
        end

        cur_req = "R4";                     // R4: keyed registers
        set_idx(8'hE7);
        step(1, 16'h03F1, 1, 0, 8'h00);  rd_val();
        step(1, 16'h03F1, 1, 0, 8'hFE);  rd_val();
        set_idx(8'hE8);
        step(1, 16'h03F1, 1, 0, 8'hBF);  rd_val();
        step(1, 16'h03F1, 1, 0, 8'hBE);  rd_val();

        cur_req = "R5";                     // R5: open register takes new value
        set_idx(8'hF4);
        step(1, 16'h03F1, 1, 0, 8'h3A);  rd_val();

        cur_req = "R8";                     // R8: outside addresses
        step(1, 16'h03F2, 1, 0, 8'h77);
        step(1, 16'h03EF, 1, 0, 8'hE0);
        step(1, 16'h03F2, 0, 1, 8'h00);
        step(1, 16'h13F0, 0, 1, 8'h00);
        rd_val();                           // still 0xF4, still 0x3A

        cur_req = "R9";                     // R9: read through selector port
        step(1, 16'h03F0, 0, 1, 8'h00);
        step(1, 16'h0000, 0, 0, 8'h00);

        cur_req = "R1";                     // R1 and R10: combined strobes
        set_idx(8'hE1);
        step(1, 16'h03F1, 1, 1, 8'h99);     // read returns old 0xA5
        step(1, 16'h03F1, 0, 1, 8'h00);
        step(1, 16'h03F0, 1, 1, 8'hE3);     // read old selector's register
        rd_val();

        cur_req = "R2";                     // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int          sel;
            sel = $urandom_range(0, 9);
            a = (sel < 4) ? 16'h03F0 : (sel < 9) ? 16'h03F1 : 16'h03F2;
            step(($urandom_range(0, 7) != 0), a, $urandom_range(0, 1),
                 $urandom_range(0, 1),
                 (sel < 4) ? 8'($urandom_range('hDC, 'hFF)) : 8'($urandom));
        end
        step(1, 16'h0000, 0, 0, 8'h00);
        step(1, 16'h0000, 0, 0, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule